// File: doc/BRIEF.md
# Daisy-Chained TDM Audio Slot Receiver

This block sits on a shared time-division-multiplexed serial audio line that several devices listen to at once. A frame clock marks the start of each sample period. The bit clock then moves through a frame of 256 bit periods. The frame is split into 32-bit packets. Packet 0 carries a command word, packets 1 to 6 are audio channel slots, and the remaining bit periods are unused. No slot is tied to a fixed index. Ownership travels down a chain of devices instead: each device's chain output feeds the chain input of the next device.

A device that sees its chain input high arms itself. At the next packet boundary that opens a channel slot, it takes the following `NUM_CH` slots as its own. It presents each slot word with a one-cycle strobe and a channel index. During its final owned slot it raises its chain output, which hands the next slot to the downstream device. The command packet is presented only when its target-ID field equals the local device ID, or when it is flagged as extended and therefore meant for every device. The serial input is echoed on a serial output half a bit later.

Top module: `tdm_chain_rx`

## Requirements
- R1: A frame begins at the rising bit-clock edge on which the frame clock is first sampled high after being low. That bit is frame bit 0. Bits arrive MSB first in 32-bit packets: packet 0 is the command and packets 1..6 are channel slots. Bits 224..255 have no effect on any output.
- R2: If chain_in is sampled high during packet k, the device owns the NUM_CH (default 2) consecutive channel slots starting at packet k+1, cut off after slot 6. If chain_in is high only in packet 6 or later, the device owns nothing in that frame.
- R3: For each owned slot, ch_data carries the full 32-bit word and ch_valid is high for exactly one bit clock, starting at the rising edge that samples the slot's last bit. ch_sel is the slot's position within the device's run: 0 for the first owned slot, 1 for the second.
- R4: chain_out is driven on falling edges. It is high from the falling edge after the first bit of the device's NUM_CH-th owned slot until the falling edge after the first bit of the next packet. It is low at all other times, and it stays low when the run was cut off before its NUM_CH-th slot.
- R5: A command word is presented (cmd_valid pulse, cmd_data = word) only if bit 31, the extended flag, is 1, or if bits 30:26 equal dev_id. Any other command word raises no cmd_valid.
- R6: Arming and ownership last only for the current frame. A frame with chain_in low throughout yields no ch_valid and no chain_out.
- R7: A frame-clock rising edge in the middle of a packet restarts the frame at bit 0. The partial packet yields no output, and the new frame then behaves normally.
- R8: dout repeats each din bit, updated on the falling edge that follows the rising edge that sampled it.
- R9: While rst_n is low, ch_valid, cmd_valid, chain_out and dout are 0.
- R10: ch_valid and cmd_valid are never high in the same cycle, and each pulse lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bck | input | 1 | Bit clock; inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrck | input | 1 | Frame clock; its rising edge starts a frame |
| din | input | 1 | Shared serial data input |
| chain_in | input | 1 | Ownership token from the upstream device |
| dev_id | input | ID_W (5) | Local device ID compared with the command target field |
| dout | output | 1 | Serial output, a half-bit-delayed copy of din |
| chain_out | output | 1 | Ownership token to the downstream device |
| ch_valid | output | 1 | One-cycle strobe for a captured channel word |
| ch_sel | output | SEL_W (1) | Position of the captured slot within the device's run |
| ch_data | output | PKT_BITS (32) | Captured channel word |
| cmd_valid | output | 1 | One-cycle strobe for an accepted command |
| cmd_data | output | PKT_BITS (32) | Accepted command word |

## Verification
The bound checker watches four things on every rising edge:
- ch_valid and cmd_valid never overlap;
- both strobes last only one cycle;
- every presented command either carries the extended flag or targets dev_id.

Only the directed frames can show the rest:
- which slots a chain_in pulse actually claims, including the cut-off at slot 6 and the ignored late pulse;
- the exact bit window of chain_out;
- that ownership does not carry from one frame into the next;
- that a premature frame edge drops the partial slot;
- that dout echoes din bit for bit.

// File: rtl/tdmc_pkg.sv
package tdmc_pkg;

   typedef enum logic [1:0] {
      SLOT_CMD   = 2'd0,
      SLOT_CHAN  = 2'd1,
      SLOT_SPARE = 2'd2
   } slot_kind_e;

   // packet 0 is the command, 1..n_chan are channel slots, the rest are spare
   function automatic slot_kind_e classify(input int unsigned pkt, input int unsigned n_chan);
      if (pkt == 0)
         return SLOT_CMD;
      else if (pkt <= n_chan)
         return SLOT_CHAN;
      else
         return SLOT_SPARE;
   endfunction

endpackage

// File: rtl/tdmc_frame_timer.sv
module tdmc_frame_timer #(
   parameter int FRAME_BITS = 256,
   parameter int BIT_W      = 5,
   parameter int IDX_W      = 9
) (
   input  logic                   bck,
   input  logic                   rst_n,
   input  logic                   lrck,
   output logic                   frame_start,
   output logic                   cur_ok,
   output logic [IDX_W-2-BIT_W:0] cur_pkt,
   output logic [BIT_W-1:0]       cur_bit,
   output logic                   post_ok,
   output logic [IDX_W-2-BIT_W:0] post_pkt
);
   localparam logic [IDX_W-1:0] IDLE = IDX_W'(FRAME_BITS);

   logic             lr_q;
   logic [IDX_W-1:0] cnt_q;
   logic [IDX_W-1:0] cur_idx;

   assign frame_start = lrck & ~lr_q;

   // a frame edge always wins, even in the middle of a packet
   always_comb begin
      if (frame_start)
         cur_idx = '0;
      else if (cnt_q == IDLE)
         cur_idx = IDLE;
      else
         cur_idx = cnt_q + IDX_W'(1);
   end

   always_ff @(posedge bck or negedge rst_n) begin
      if (!rst_n) begin
         lr_q  <= 1'b0;
         cnt_q <= IDLE;
      end else begin
         lr_q  <= lrck;
         cnt_q <= cur_idx;
      end
   end

   assign cur_ok   = cur_idx < IDLE;
   assign cur_pkt  = cur_idx[IDX_W-2:BIT_W];
   assign cur_bit  = cur_idx[BIT_W-1:0];
   assign post_ok  = cnt_q < IDLE;
   assign post_pkt = cnt_q[IDX_W-2:BIT_W];

endmodule

// File: rtl/tdmc_slot_owner.sv
module tdmc_slot_owner #(
   parameter int CH_SLOTS = 6,
   parameter int NUM_CH   = 2,
   parameter int PKT_W    = 3,
   parameter int SEL_W    = 1
) (
   input  logic             bck,
   input  logic             rst_n,
   input  logic             frame_start,
   input  logic             cur_ok,
   input  logic             first_bit,
   input  logic             chain_in,
   input  logic [PKT_W-1:0] pkt,
   input  logic             post_ok,
   input  logic [PKT_W-1:0] post_pkt,
   output logic             owned,
   output logic [SEL_W-1:0] owned_sel,
   output logic             last_post
);
   import tdmc_pkg::*;

   localparam logic [PKT_W:0]   SPAN      = (PKT_W+1)'(NUM_CH);
   localparam logic [PKT_W-1:0] LAST_OFFS = PKT_W'(NUM_CH - 1);

   logic             arm_q;
   logic             taken_q;
   logic [PKT_W-1:0] base_q;
   logic             cur_chan;
   logic             post_chan;
   logic             start_now;
   logic             eff_taken;
   logic [PKT_W-1:0] eff_base;
   logic [PKT_W-1:0] offs;
   logic [PKT_W-1:0] post_offs;

   assign cur_chan  = classify(int'(pkt), CH_SLOTS) == SLOT_CHAN;
   assign post_chan = classify(int'(post_pkt), CH_SLOTS) == SLOT_CHAN;

   // a run starts at the first channel boundary after the token was seen
   assign start_now = cur_ok && first_bit && cur_chan && arm_q && !taken_q && !frame_start;
   assign eff_taken = taken_q | start_now;
   assign eff_base  = start_now ? pkt : base_q;
   assign offs      = pkt - eff_base;
   assign owned     = cur_ok && eff_taken && cur_chan && (pkt >= eff_base) && ({1'b0, offs} < SPAN);

   generate
      if (NUM_CH == 1) begin : g_sel_single
         assign owned_sel = '0;
      end else begin : g_sel_multi
         assign owned_sel = offs[SEL_W-1:0];
      end
   endgenerate

   assign post_offs = post_pkt - base_q;
   assign last_post = post_ok && taken_q && post_chan && (post_pkt >= base_q) && (post_offs == LAST_OFFS);

   always_ff @(posedge bck or negedge rst_n) begin
      if (!rst_n) begin
         arm_q   <= 1'b0;
         taken_q <= 1'b0;
         base_q  <= '0;
      end else if (frame_start) begin
         arm_q   <= chain_in;
         taken_q <= 1'b0;
         base_q  <= '0;
      end else if (cur_ok) begin
         if (start_now) begin
            arm_q   <= 1'b0;
            taken_q <= 1'b1;
            base_q  <= pkt;
         end else if (chain_in && !taken_q) begin
            arm_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/tdmc_word_capture.sv
module tdmc_word_capture #(
   parameter int PKT_BITS = 32,
   parameter int ID_W     = 5,
   parameter int SEL_W    = 1
) (
   input  logic                bck,
   input  logic                rst_n,
   input  logic                din,
   input  logic                cur_ok,
   input  logic                last_bit,
   input  logic                is_cmd,
   input  logic                owned,
   input  logic [SEL_W-1:0]    owned_sel,
   input  logic [ID_W-1:0]     dev_id,
   output logic                din_q,
   output logic                ch_valid,
   output logic [SEL_W-1:0]    ch_sel,
   output logic [PKT_BITS-1:0] ch_data,
   output logic                cmd_valid,
   output logic [PKT_BITS-1:0] cmd_data
);
   logic [PKT_BITS-2:0] sh_q;
   logic [PKT_BITS-1:0] word;
   logic                cmd_hit;
   logic                word_done;

   assign word      = {sh_q, din};
   assign word_done = cur_ok && last_bit;
   assign cmd_hit   = word[PKT_BITS-1] || (word[PKT_BITS-2 -: ID_W] == dev_id);

   always_ff @(posedge bck or negedge rst_n) begin
      if (!rst_n) begin
         sh_q      <= '0;
         din_q     <= 1'b0;
         ch_valid  <= 1'b0;
         ch_sel    <= '0;
         ch_data   <= '0;
         cmd_valid <= 1'b0;
         cmd_data  <= '0;
      end else begin
         sh_q      <= word[PKT_BITS-2:0];
         din_q     <= din;
         ch_valid  <= 1'b0;
         cmd_valid <= 1'b0;
         if (word_done && is_cmd && cmd_hit) begin
            cmd_valid <= 1'b1;
            cmd_data  <= word;
         end
         if (word_done && owned) begin
            ch_valid <= 1'b1;
            ch_sel   <= owned_sel;
            ch_data  <= word;
         end
      end
   end

endmodule

// File: rtl/tdm_chain_rx.sv
module tdm_chain_rx #(
   parameter int PKT_BITS   = 32,
   parameter int FRAME_BITS = 256,
   parameter int CH_SLOTS   = 6,
   parameter int NUM_CH     = 2,
   parameter int ID_W       = 5,
   parameter int MAX_DEV    = 30,
   localparam int SEL_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                bck,
   input  logic                rst_n,
   input  logic                lrck,
   input  logic                din,
   input  logic                chain_in,
   input  logic [ID_W-1:0]     dev_id,
   output logic                dout,
   output logic                chain_out,
   output logic                ch_valid,
   output logic [SEL_W-1:0]    ch_sel,
   output logic [PKT_BITS-1:0] ch_data,
   output logic                cmd_valid,
   output logic [PKT_BITS-1:0] cmd_data
);
   localparam int IDX_W = $clog2(FRAME_BITS) + 1;
   localparam int BIT_W = $clog2(PKT_BITS);
   localparam int PKT_W = IDX_W - 1 - BIT_W;

   // elaboration checks on the parameter set
   generate
      if ((1 << BIT_W) != PKT_BITS) begin : g_bad_pkt
         $error("PKT_BITS must be a power of two");
      end
      if ((1 << (IDX_W - 1)) != FRAME_BITS) begin : g_bad_frame
         $error("FRAME_BITS must be a power of two");
      end
      if ((CH_SLOTS + 1) * PKT_BITS > FRAME_BITS) begin : g_bad_slots
         $error("command plus channel slots exceed the frame");
      end
      if (NUM_CH < 1 || NUM_CH > CH_SLOTS) begin : g_bad_nch
         $error("NUM_CH out of range");
      end
      if (ID_W + 1 > PKT_BITS || MAX_DEV >= (1 << ID_W)) begin : g_bad_id
         $error("ID field too narrow or too wide");
      end
   endgenerate

   logic             frame_start;
   logic             cur_ok;
   logic [PKT_W-1:0] cur_pkt;
   logic [BIT_W-1:0] cur_bit;
   logic             post_ok;
   logic [PKT_W-1:0] post_pkt;
   logic             owned;
   logic [SEL_W-1:0] owned_sel;
   logic             last_post;
   logic             din_q;

   tdmc_frame_timer #(
      .FRAME_BITS(FRAME_BITS),
      .BIT_W     (BIT_W),
      .IDX_W     (IDX_W)
   ) i_timer (
      .bck        (bck),
      .rst_n      (rst_n),
      .lrck       (lrck),
      .frame_start(frame_start),
      .cur_ok     (cur_ok),
      .cur_pkt    (cur_pkt),
      .cur_bit    (cur_bit),
      .post_ok    (post_ok),
      .post_pkt   (post_pkt)
   );

   tdmc_slot_owner #(
      .CH_SLOTS(CH_SLOTS),
      .NUM_CH  (NUM_CH),
      .PKT_W   (PKT_W),
      .SEL_W   (SEL_W)
   ) i_owner (
      .bck        (bck),
      .rst_n      (rst_n),
      .frame_start(frame_start),
      .cur_ok     (cur_ok),
      .first_bit  (cur_bit == '0),
      .chain_in   (chain_in),
      .pkt        (cur_pkt),
      .post_ok    (post_ok),
      .post_pkt   (post_pkt),
      .owned      (owned),
      .owned_sel  (owned_sel),
      .last_post  (last_post)
   );

   tdmc_word_capture #(
      .PKT_BITS(PKT_BITS),
      .ID_W    (ID_W),
      .SEL_W   (SEL_W)
   ) i_capture (
      .bck      (bck),
      .rst_n    (rst_n),
      .din      (din),
      .cur_ok   (cur_ok),
      .last_bit (cur_bit == '1),
      .is_cmd   (cur_pkt == '0),
      .owned    (owned),
      .owned_sel(owned_sel),
      .dev_id   (dev_id),
      .din_q    (din_q),
      .ch_valid (ch_valid),
      .ch_sel   (ch_sel),
      .ch_data  (ch_data),
      .cmd_valid(cmd_valid),
      .cmd_data (cmd_data)
   );

   // launch side: token and echo change half a bit after sampling
   always_ff @(negedge bck or negedge rst_n) begin
      if (!rst_n) begin
         chain_out <= 1'b0;
         dout      <= 1'b0;
      end else begin
         chain_out <= last_post;
         dout      <= din_q;
      end
   end

endmodule

// File: rtl/tdm_chain_rx_chk.sv
module tdm_chain_rx_chk #(
   parameter int PKT_BITS = 32,
   parameter int ID_W     = 5
) (
   input logic                bck,
   input logic                rst_n,
   input logic [ID_W-1:0]     dev_id,
   input logic                ch_valid,
   input logic                cmd_valid,
   input logic [PKT_BITS-1:0] cmd_data
);

   // R10
   strobe_excl_chk: assert property (@(posedge bck) disable iff (!rst_n)
      !(ch_valid && cmd_valid));

   // R10
   cmd_pulse_chk: assert property (@(posedge bck) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid);

   // R3
   ch_pulse_chk: assert property (@(posedge bck) disable iff (!rst_n)
      ch_valid |=> !ch_valid);

   // R5
   cmd_target_chk: assert property (@(posedge bck) disable iff (!rst_n)
      cmd_valid |-> (cmd_data[PKT_BITS-1] || (cmd_data[PKT_BITS-2 -: ID_W] == dev_id)));

endmodule

bind tdm_chain_rx tdm_chain_rx_chk #(
   .PKT_BITS(PKT_BITS),
   .ID_W    (ID_W)
) i_chk (
   .bck      (bck),
   .rst_n    (rst_n),
   .dev_id   (dev_id),
   .ch_valid (ch_valid),
   .cmd_valid(cmd_valid),
   .cmd_data (cmd_data)
);

// File: tb/test_tdm_chain_rx.sv
module test_tdm_chain_rx;

   logic        bck = 1'b0;
   logic        rst_n = 1'b0;
   logic        lrck = 1'b0;
   logic        din = 1'b0;
   logic        chain_in = 1'b0;
   logic [4:0]  dev_id = 5'd3;
   logic        dout;
   logic        chain_out;
   logic        ch_valid;
   logic        ch_sel;
   logic [31:0] ch_data;
   logic        cmd_valid;
   logic [31:0] cmd_data;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   logic [31:0] pk [7];
   logic        co_log [256];
   logic        do_log [256];
   logic        di_log [256];
   int          cap_n;
   logic [31:0] cap_d [8];
   logic        cap_s [8];
   int          cap_b [8];
   int          cmd_n;
   logic [31:0] cmd_d;

   always #4 bck = ~bck;

   tdm_chain_rx i_tdm_chain_rx (
      .bck      (bck),
      .rst_n    (rst_n),
      .lrck     (lrck),
      .din      (din),
      .chain_in (chain_in),
      .dev_id   (dev_id),
      .dout     (dout),
      .chain_out(chain_out),
      .ch_valid (ch_valid),
      .ch_sel   (ch_sel),
      .ch_data  (ch_data),
      .cmd_valid(cmd_valid),
      .cmd_data (cmd_data)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic observe(input int idx);
      co_log[idx] = chain_out;
      do_log[idx] = dout;
      if (ch_valid && cap_n < 8) begin
         cap_d[cap_n] = ch_data;
         cap_s[cap_n] = ch_sel;
         cap_b[cap_n] = idx;
         cap_n++;
      end
      if (cmd_valid) begin
         cmd_n++;
         cmd_d = cmd_data;
      end
   endtask

   // drives nbits of a frame, chain_in high through packet ci_pkt
   task automatic run_frame(input int ci_pkt, input int nbits);
      cap_n = 0;
      cmd_n = 0;
      for (int b = 0; b <= nbits; b++) begin
         @(negedge bck);
         #1;
         if (b > 0) observe(b - 1);
         if (b < nbits) begin
            lrck     = (b < 4);
            chain_in = ((b / 32) == ci_pkt);
            din      = ((b / 32) < 7) ? pk[b / 32][31 - (b % 32)] : 1'b1;
            di_log[b] = din;
         end else begin
            lrck     = 1'b0;
            chain_in = 1'b0;
            din      = 1'b0;
         end
      end
   endtask

   // expected results derived from the requirements
   task automatic check_frame(input int ci_pkt, input int nbits, input bit exp_cmd, input string tag);
      int start;
      int exp_caps;
      int bad_co;
      int bad_do;
      int first_bad;
      start = ci_pkt + 1;
      exp_caps = 0;
      if (ci_pkt >= 0 && start <= 6) begin
         for (int s = start; s <= start + 1 && s <= 6; s++) begin
            if (32 * s + 31 < nbits) begin
               if (exp_caps < cap_n) begin
                  // R3 word, position and strobe timing
                  chk(cap_d[exp_caps] == pk[s], "R3", {tag, " slot word"}, 64'(cap_d[exp_caps]), 64'(pk[s]));
                  chk(cap_s[exp_caps] == 1'(s - start), "R3", {tag, " slot sel"}, 64'(cap_s[exp_caps]), 64'(s - start));
                  chk(cap_b[exp_caps] == 32 * s + 31, "R3", {tag, " strobe bit"}, 64'(cap_b[exp_caps]), 64'(32 * s + 31));
               end
               exp_caps++;
            end
         end
      end
      // R2 R6 R7 number of captured slots
      chk(cap_n == exp_caps, "R2", {tag, " capture count"}, 64'(cap_n), 64'(exp_caps));
      // R4 token window
      bad_co = 0;
      first_bad = -1;
      for (int b = 0; b < nbits; b++) begin
         logic e;
         e = (ci_pkt >= 0) && (start + 1 <= 6) && ((b / 32) == start + 1);
         if (co_log[b] !== e) begin
            bad_co++;
            if (first_bad < 0) first_bad = b;
         end
      end
      chk(bad_co == 0, "R4", {tag, " chain_out bits wrong, first at"}, 64'(first_bad), 64'(-1));
      // R8 echo
      bad_do = 0;
      for (int b = 0; b < nbits; b++)
         if (do_log[b] !== di_log[b]) bad_do++;
      chk(bad_do == 0, "R8", {tag, " dout mismatches"}, 64'(bad_do), 64'(0));
      // R5 command acceptance
      if (exp_cmd && nbits >= 32) begin
         chk(cmd_n == 1, "R5", {tag, " cmd count"}, 64'(cmd_n), 64'(1));
         chk(cmd_d == pk[0], "R5", {tag, " cmd word"}, 64'(cmd_d), 64'(pk[0]));
      end else begin
         chk(cmd_n == 0, "R5", {tag, " ignored cmd count"}, 64'(cmd_n), 64'(0));
      end
   endtask

   task automatic fill(input logic [31:0] cmd, input logic [31:0] seed);
      pk[0] = cmd;
      for (int i = 1; i < 7; i++) pk[i] = seed ^ (32'h1111_0000 * i) ^ (32'h0000_0F0F << i);
   endtask

   task automatic t_reset;
      // R9
      chk({ch_valid, cmd_valid, chain_out, dout} == 4'b0, "R9", "outputs in reset",
          64'({ch_valid, cmd_valid, chain_out, dout}), 64'(0));
   endtask

   task automatic t_first_owner;
      // R1 R2 R3 R4 R5: owner of slots 1 and 2, matching command target
      fill({1'b0, 5'd3, 26'h2A5_5A5A}, 32'hA5C3_0F96);
      run_frame(0, 256);
      check_frame(0, 256, 1'b1, "first owner");
   endtask

   task automatic t_mid_owner;
      // R2 R4 R5: token in packet 3, command for another device
      fill({1'b0, 5'd9, 26'h155_1234}, 32'h3C5A_7E01);
      run_frame(3, 256);
      check_frame(3, 256, 1'b0, "mid owner");
   endtask

   task automatic t_idle_ext;
      // R6 R5: no token this frame, extended command for everyone
      fill({1'b1, 5'd17, 26'h0AB_CDEF}, 32'h0F0F_F0F0);
      run_frame(-1, 256);
      check_frame(-1, 256, 1'b1, "idle frame");
   endtask

   task automatic t_clip;
      // R2 R4: run cut off at slot 6, no hand-off
      fill({1'b0, 5'd3, 26'h000_0001}, 32'h8001_7FFE);
      run_frame(5, 256);
      check_frame(5, 256, 1'b1, "clipped run");
   endtask

   task automatic t_late;
      // R2 R1: token in packet 6 claims nothing, spare bits ignored
      fill({1'b0, 5'd0, 26'h3FF_FFFF}, 32'hDEAD_BEEF);
      run_frame(6, 256);
      check_frame(6, 256, 1'b0, "late token");
   endtask

   task automatic t_resync;
      // R7: frame cut inside slot 1, then a full frame
      fill({1'b0, 5'd3, 26'h111_2222}, 32'h1357_9BDF);
      run_frame(0, 40);
      check_frame(0, 40, 1'b1, "cut frame");
      fill({1'b0, 5'd3, 26'h333_4444}, 32'h2468_ACE0);
      run_frame(0, 256);
      check_frame(0, 256, 1'b1, "after resync");
   endtask

   initial begin
      repeat (3) @(posedge bck);
      @(negedge bck);
      #1;
      t_reset();
      rst_n = 1'b1;
      repeat (3) @(posedge bck);
      t_first_owner();
      t_mid_owner();
      t_idle_ext();
      t_clip();
      t_late();
      t_resync();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge bck);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule